// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Responder

This block stands in for a 16-bit asynchronous static RAM on an external memory bus. A controller drives it through active-low select, write strobe, output strobe and one enable per byte lane, plus an address. The bidirectional data bus appears as an input word, an output word and a drive-enable bit for each byte lane. The pad ring or the bench turns these into a tri-state bus. Storage is an internal array of 16-bit words, and each byte lane keeps its own storage.

The pins carry no clock, so a fast internal clock oversamples them through a two-stage synchronizer. A write lasts as long as select, write strobe and the lane's enable are all low together. It is committed when the first of them rises, using the address and data present in the last sample before that rise. A read drives only the lanes whose enable is low, and it follows address changes with no latency beyond the synchronizer.

Top module: `sram_lane_responder`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits (ADDR_W=16 gives 65,536 words; the default is 10). A word written and later read at the same address returns the written value.
- R2: Lane i is written only while `ce_n`, `we_n` and that lane's enable are all low. The write is committed when the first of those three rises, and a lane whose enable stays high keeps its old contents.
- R3: `lb_n` gates data bits 7:0 and drive bit `dq_oe[0]`. `ub_n` gates data bits 15:8 and drive bit `dq_oe[1]`. This holds for both reads and writes.
- R4: A read needs `ce_n`=0, `oe_n`=0 and `we_n`=1. During a read, each lane whose enable is low is driven with the stored byte. A lane that is not driven shows zero on `dq_out`.
- R5: No lane is driven while `ce_n` is high, while `oe_n` is high, while both lane enables are high, or while `ce_n` and `we_n` are both low.
- R6: Selected with outputs disabled (output strobe high with write strobe high, or both lane enables high) drives nothing and changes no stored word.
- R7: The data and address committed are those present in the last sample before the write-ending edge. Data that changes earlier in the write window is discarded.
- R8: When `ce_n` and `we_n` rise in the same instant, the write is committed and no lane is driven afterwards.
- R9: With a read held active, a new address shows its stored data on `dq_out` two clock edges after it is applied.
- R10: During reset and right after it, `dq_oe` is 0 and no write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Active-low reset of the sampling stages |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| lb_n | input | 1 | Active-low enable for bits 7:0 |
| ub_n | input | 1 | Active-low enable for bits 15:8 |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data arriving on the bus |
| dq_out | output | 16 | Data to drive onto the bus |
| dq_oe | output | 2 | Drive enable per byte lane (bit 0 low byte) |

## Verification
The bench goes after writes that end by a lane enable rising, with the other lane still open. A design that ended writes on the word-wide overlap would store the wrong byte in the lane that closed first.

It also changes data partway through a write window. A design that captured data at the start of the window, or one sample late, would store the stale or the following value.

Writes with both lane enables high and writes while deselected must leave the stored word untouched. Write cycles with the output strobe low must keep the bus undriven, and so must the case where select and write strobe rise together. A design that keyed drive on the output strobe alone would contend with the controller there.

// File: rtl/sram_lane_responder.sv
module sram_lane_responder #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic                  lb_n,
  input  logic                  ub_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   dq_in,
  output logic [2*LANE_W-1:0]   dq_out,
  output logic [1:0]            dq_oe
);
  localparam int DATA_W = 2 * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [4:0]        ctl_s1, ctl_s2;
  logic [ADDR_W-1:0] a_s1, a_s2, a_s3;
  logic [DATA_W-1:0] d_s1, d_s2, d_s3;
  logic [1:0]        wl_s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1 <= '1;
      ctl_s2 <= '1;
      a_s1   <= '0;
      a_s2   <= '0;
      a_s3   <= '0;
      d_s1   <= '0;
      d_s2   <= '0;
      d_s3   <= '0;
      wl_s3  <= '0;
    end else begin
      ctl_s1 <= {ub_n, lb_n, oe_n, we_n, ce_n};
      ctl_s2 <= ctl_s1;
      a_s1   <= addr;
      a_s2   <= a_s1;
      a_s3   <= a_s2;
      d_s1   <= dq_in;
      d_s2   <= d_s1;
      d_s3   <= d_s2;
      wl_s3  <= wl_s2;
    end
  end

  wire       sel   = ~ctl_s2[0];
  wire       wr_on = ~ctl_s2[1];
  wire       rd_on = ~ctl_s2[2];
  wire [1:0] lane  = ~ctl_s2[4:3];
  wire       rd_act = sel & rd_on & ~wr_on;

  logic [1:0] wl_s2, commit;
  assign wl_s2  = {2{sel & wr_on}} & lane;
  assign commit = wl_s3 & ~wl_s2;
  assign dq_oe  = {2{rd_act}} & lane;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (commit[i]) store[a_s3] <= d_s3[i*LANE_W +: LANE_W];
    end

    assign dq_out[i*LANE_W +: LANE_W] = dq_oe[i] ? store[a_s2] : '0;
  end
endmodule

module sram_lane_responder_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce_n,
  input logic                we_n,
  input logic                oe_n,
  input logic                lb_n,
  input logic                ub_n,
  input logic [2*LANE_W-1:0] dq_out,
  input logic [1:0]          dq_oe,
  input logic [1:0]          commit
);
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> $past(!ce_n && !oe_n && we_n, 2));  // R4
  AST_LOW_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> $past(!lb_n, 2));  // R3
  AST_HIGH_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[1] |-> $past(!ub_n, 2));  // R3
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ce_n && !we_n, 2) |-> dq_oe == 2'b00);  // R5
  AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe[0] |-> dq_out[LANE_W-1:0] == '0);  // R4
  AST_LOW_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    commit[0] |-> $past(!ce_n && !we_n && !lb_n, 3) && !$past(!ce_n && !we_n && !lb_n, 2));  // R2
  AST_HIGH_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    commit[1] |-> $past(!ce_n && !we_n && !ub_n, 3) && !$past(!ce_n && !we_n && !ub_n, 2));  // R2
endmodule

bind sram_lane_responder sram_lane_responder_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .lb_n(lb_n), .ub_n(ub_n), .dq_out(dq_out), .dq_oe(dq_oe), .commit(commit)
);

// File: tb/sram_lane_responder_bench.sv
module sram_lane_responder_bench;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1, lb_n = 1, ub_n = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out;
  logic [1:0] dq_oe;

  always #4 clk = ~clk;

  sram_lane_responder #(.ADDR_W(AW), .LANE_W(8)) u_sram_lane_responder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct { string req; logic [1:0] oe; logic [15:0] data; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] model [int];

  always begin
    @(negedge clk);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (dq_oe !== it.oe || dq_out !== it.data) begin
        errors++;
        $display("FAIL %s: got oe=%b data=%h, expected oe=%b data=%h",
                 it.req, dq_oe, dq_out, it.oe, it.data);
      end
    end
  end

  task automatic expect_out(string req, logic [1:0] oe, logic [15:0] data);
    item_t it;
    it.req = req; it.oe = oe; it.data = data;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] mask(logic [15:0] v, logic [1:0] l);
    return {l[1] ? v[15:8] : 8'h00, l[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic idle();
    ce_n = 1; we_n = 1; oe_n = 1; lb_n = 1; ub_n = 1;
    settle();
  endtask

  task automatic write_we(int a, logic [15:0] d, logic [1:0] l);
    addr = a[AW-1:0]; dq_in = d;
    ce_n = 0; oe_n = 1; lb_n = ~l[0]; ub_n = ~l[1];
    settle();
    we_n = 0; settle();
    we_n = 1; settle();
    idle();
    model[a] = {l[1] ? d[15:8] : model[a][15:8], l[0] ? d[7:0] : model[a][7:0]};
  endtask

  task automatic read_chk(string req, int a, logic [1:0] l);
    addr = a[AW-1:0];
    ce_n = 0; we_n = 1; oe_n = 0; lb_n = ~l[0]; ub_n = ~l[1];
    settle();
    expect_out(req, l, mask(model[a], l));
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out("R10 reset", 2'b00, 16'h0000);
    rst_n = 1;
    settle();
    expect_out("R10 after reset", 2'b00, 16'h0000);

    write_we(5, 16'hA5A5, 2'b11);
    read_chk("R1 full word", 5, 2'b11);
    write_we(6, 16'h0F0F, 2'b11);
    write_we(5, 16'h1234, 2'b01);
    read_chk("R2 low-only write", 5, 2'b11);
    write_we(5, 16'hBEEF, 2'b10);
    read_chk("R2 high-only write", 5, 2'b11);
    read_chk("R3 low lane read", 5, 2'b01);
    read_chk("R3 high lane read", 5, 2'b10);

    // R2: write ended by chip select rising
    addr = 7; dq_in = 16'h5A3C; we_n = 0; lb_n = 0; ub_n = 0; settle();
    ce_n = 0; settle();
    ce_n = 1; settle();
    idle(); model[7] = 16'h5A3C;
    read_chk("R2 select-ended write", 7, 2'b11);

    // R2 R7: lanes closed one after another, data changes between
    addr = 8; dq_in = 16'h1111; ce_n = 0; we_n = 0; lb_n = 0; ub_n = 0; settle();
    dq_in = 16'h2233; settle();
    lb_n = 1; settle();
    dq_in = 16'h4455; settle();
    ub_n = 1; settle();
    idle(); model[8] = 16'h4433;
    read_chk("R7 per-lane end data", 8, 2'b11);

    // R5: write with output strobe low drives nothing
    addr = 9; dq_in = 16'hC0DE; ce_n = 0; oe_n = 0; lb_n = 0; ub_n = 0; we_n = 0; settle();
    expect_out("R5 write with oe low", 2'b00, 16'h0000);
    // R8: select and write strobe rise together
    ce_n = 1; we_n = 1; settle();
    expect_out("R8 joint rise no drive", 2'b00, 16'h0000);
    idle(); model[9] = 16'hC0DE;
    read_chk("R8 joint rise committed", 9, 2'b11);

    // R5: deselected / outputs off / lanes off
    addr = 5; ce_n = 1; oe_n = 0; lb_n = 0; ub_n = 0; settle();
    expect_out("R5 deselected", 2'b00, 16'h0000);
    ce_n = 0; oe_n = 1; settle();
    expect_out("R5 oe high", 2'b00, 16'h0000);
    oe_n = 0; lb_n = 1; ub_n = 1; settle();
    expect_out("R5 lanes off", 2'b00, 16'h0000);
    idle();

    // R6: strobe with both lanes off, and strobe while deselected
    addr = 5; dq_in = 16'hDEAD; ce_n = 0; lb_n = 1; ub_n = 1; settle();
    we_n = 0; settle(); we_n = 1; settle();
    ce_n = 1; lb_n = 0; ub_n = 0; settle();
    we_n = 0; settle(); we_n = 1; settle();
    idle();
    read_chk("R6 no write when disabled", 5, 2'b11);

    // R9: address change during an active read
    addr = 5; ce_n = 0; we_n = 1; oe_n = 0; lb_n = 0; ub_n = 0; settle();
    expect_out("R9 first address", 2'b11, model[5]);
    addr = 6; settle();
    expect_out("R9 new address", 2'b11, model[6]);
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule